// File: doc/BRIEF.md
# Hardware Power-Down and Wake Sequencer

This block turns an active-low power-down request pin into an ordered sequence of chip-level controls. While the pin reads high, the chip runs normally. When the sampled pin is low, the block first holds the core in reset for a fixed number of machine cycles with the clocks still running. That reset stops the watchdog timer and clears its status, the same as a hardware reset. Only then does it switch off both oscillators and put the pads into their floating state.

The chip stays in that state for as long as the pin stays low. When the pin returns high, the block wakes the chip in steps. It first drives the pads again in their reset state. If the oscillator-watchdog strap is set, it then turns both oscillators back on. While the main oscillator is not yet ready, the core stays in reset and runs from the fast RC clock, and the oscillator-watchdog flag shows the failure. Once the main oscillator reports ready, the block returns the clock to the main oscillator, clears the flag and lets the core out of reset. If the auto-start strap is set, it also starts the watchdog timer.

Every step advances only on a machine-cycle strobe. The external reset pin overrides the whole sequence at any time.

Top module: `pdw_ctrl`

## Requirements
- R1: While `ext_rst_ni` is low, `core_rst_o` is 1 and the block returns to the running state from any state, with `main_osc_en_o`=1, `pad_float_o`=0, `clk_sel_rc_o`=0 and `owd_flag_o`=0. After `ext_rst_ni` rises with the pin high, `core_rst_o` is 0.
- R2: `pd_pin_ni` passes through a synchronizer of `SYNC_STAGES` flops and acts only on a clock edge where `mc_stb_i` is 1. A low pulse that has left the synchronizer before the next strobe has no effect. A low level seen at a strobe in the running state starts the entry reset.
- R3: The entry reset holds `core_rst_o`=1 with `main_osc_en_o`=1 for exactly `RST_MC` machine cycles, counting the entry strobe. At the next strobe, `main_osc_en_o` and `rc_osc_en_o` go to 0 and `pad_float_o` goes to 1.
- R4: The powered-down outputs (`pad_float_o`=1, both oscillator enables 0, `core_rst_o`=1) hold for every strobe at which the pin is sampled low.
- R5: At the first strobe that samples the pin high while powered down, `pad_float_o` falls to 0. `core_rst_o` stays 1 and both oscillator enables stay 0.
- R6: With `osc_wd_en_i`=0 the block stays in that pad-restored state with the oscillators off until an external reset. With `osc_wd_en_i`=1, the next strobe sets `main_osc_en_o`, `rc_osc_en_o`, `clk_sel_rc_o` and `owd_flag_o` all to 1.
- R7: While `main_osc_rdy_i` is 0 at each strobe, `core_rst_o`=1 and `clk_sel_rc_o`=1 hold.
- R8: The strobe that samples `main_osc_rdy_i`=1 clears `clk_sel_rc_o` and `owd_flag_o` while `core_rst_o` stays 1. The following strobe drops `core_rst_o` to 0.
- R9: On the edge where `core_rst_o` is released, `wdt_start_o` pulses 1 for one clock if `wdt_auto_i`=1, and stays 0 otherwise. In the running state `rc_osc_en_o` equals `osc_wd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| mc_stb_i | input | 1 | Machine-cycle strobe, one clock wide |
| pd_pin_ni | input | 1 | Power-down request pin, active low, asynchronous |
| osc_wd_en_i | input | 1 | Oscillator-watchdog enable strap |
| wdt_auto_i | input | 1 | Watchdog auto-start strap |
| main_osc_rdy_i | input | 1 | Main oscillator reported running |
| core_rst_o | output | 1 | Internal reset to the core |
| main_osc_en_o | output | 1 | Main oscillator enable |
| rc_osc_en_o | output | 1 | RC oscillator enable |
| pad_float_o | output | 1 | Ports and control lines float |
| clk_sel_rc_o | output | 1 | Core clock taken from the RC oscillator |
| owd_flag_o | output | 1 | Oscillator-watchdog failure flag |
| wdt_start_o | output | 1 | One-clock watchdog start pulse |

## Verification
The hardest situation to reach is an external reset that lands in a late wake state, such as the oscillator wait or the release cycle. Those states exist only after a full entry reset, a stay in power-down and a pin release. The bench therefore drives the block to each of the six states in turn by replaying that prefix one strobe at a time, then pulls the reset pin. The strap combinations are swept over complete power-down and wake cycles. The short pin pulse is timed to leave the synchronizer before the next strobe.

// File: rtl/pdw_pkg.sv
`timescale 1ns/1ps
package pdw_pkg;
   typedef enum logic [2:0] {
      PDW_RUN         = 3'd0,
      PDW_ENTRY_RST   = 3'd1,
      PDW_DOWN        = 3'd2,
      PDW_PAD_RESTORE = 3'd3,
      PDW_OSC_WAIT    = 3'd4,
      PDW_RELEASE     = 3'd5
   } pdw_state_e;
endpackage

// File: rtl/pdw_sync.sv
`timescale 1ns/1ps
module pdw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pdw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     chain_q[i] <= RST_VAL;
         else if (i == 0) chain_q[i] <= d_i;
         else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdw_mc_cnt.sv
`timescale 1ns/1ps
module pdw_mc_cnt #(
   parameter int LIMIT = 24
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("pdw_mc_cnt: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pdw_ctrl.sv
`timescale 1ns/1ps
module pdw_ctrl #(
   parameter int RST_MC      = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic ext_rst_ni,
   input  logic mc_stb_i,
   input  logic pd_pin_ni,
   input  logic osc_wd_en_i,
   input  logic wdt_auto_i,
   input  logic main_osc_rdy_i,
   output logic core_rst_o,
   output logic main_osc_en_o,
   output logic rc_osc_en_o,
   output logic pad_float_o,
   output logic clk_sel_rc_o,
   output logic owd_flag_o,
   output logic wdt_start_o
);
   import pdw_pkg::*;

   pdw_state_e state_q, state_d;
   logic       pin_sync_n;
   logic       pd_req;
   logic       phase_last;
   logic       wdt_start_q;
   logic       osc_on;

   pdw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk_i  (clk_i),
      .rst_ni (ext_rst_ni),
      .d_i    (pd_pin_ni),
      .q_o    (pin_sync_n)
   );

   assign pd_req = mc_stb_i && !pin_sync_n;

   pdw_mc_cnt #(.LIMIT(RST_MC)) u_entry_cnt (
      .clk_i  (clk_i),
      .rst_ni (ext_rst_ni),
      .clr_i  (state_q != PDW_ENTRY_RST),
      .inc_i  (mc_stb_i && state_q == PDW_ENTRY_RST),
      .last_o (phase_last)
   );

   always_comb begin
      state_d = state_q;
      if (mc_stb_i) begin
         unique case (state_q)
            PDW_RUN:         if (pd_req) state_d = PDW_ENTRY_RST;
            PDW_ENTRY_RST:   if (phase_last) state_d = PDW_DOWN;
            PDW_DOWN:        if (pin_sync_n) state_d = PDW_PAD_RESTORE;
            PDW_PAD_RESTORE: if (osc_wd_en_i) state_d = PDW_OSC_WAIT;
            PDW_OSC_WAIT:    if (main_osc_rdy_i) state_d = PDW_RELEASE;
            PDW_RELEASE:     state_d = PDW_RUN;
            default:         state_d = PDW_RUN;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge ext_rst_ni) begin
      if (!ext_rst_ni) begin
         state_q     <= PDW_RUN;
         wdt_start_q <= 1'b0;
      end else begin
         state_q     <= state_d;
         wdt_start_q <= mc_stb_i && (state_q == PDW_RELEASE) && wdt_auto_i;
      end
   end

   assign osc_on = (state_q == PDW_RUN) || (state_q == PDW_ENTRY_RST) ||
                   (state_q == PDW_OSC_WAIT) || (state_q == PDW_RELEASE);

   assign core_rst_o    = !ext_rst_ni || (state_q != PDW_RUN);
   assign main_osc_en_o = osc_on;
   assign rc_osc_en_o   = osc_on && osc_wd_en_i;
   assign pad_float_o   = (state_q == PDW_DOWN);
   assign clk_sel_rc_o  = (state_q == PDW_OSC_WAIT);
   assign owd_flag_o    = (state_q == PDW_OSC_WAIT);
   assign wdt_start_o   = wdt_start_q;
endmodule

// File: rtl/pdw_ctrl_chk.sv
`timescale 1ns/1ps
module pdw_ctrl_chk #(
   parameter int RST_MC = 24
) (
   input logic       clk_i,
   input logic       ext_rst_ni,
   input logic       mc_stb_i,
   input logic       osc_wd_en_i,
   input logic       wdt_auto_i,
   input logic       core_rst_o,
   input logic       main_osc_en_o,
   input logic       rc_osc_en_o,
   input logic       pad_float_o,
   input logic       clk_sel_rc_o,
   input logic       owd_flag_o,
   input logic       wdt_start_o,
   input logic [2:0] state_q
);
   int unsigned entry_stb;

   always_ff @(posedge clk_i or negedge ext_rst_ni) begin
      if (!ext_rst_ni)                            entry_stb <= 0;
      else if (state_q != pdw_pkg::PDW_ENTRY_RST) entry_stb <= 0;
      else if (mc_stb_i)                          entry_stb <= entry_stb + 1;
   end

   always_comb begin
      if (!ext_rst_ni) AST_EXT_RST_HOLDS: assert (core_rst_o); // R1
   end

   AST_FLOAT_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      $rose(pad_float_o) |-> $past(core_rst_o) && $past(main_osc_en_o)); // R3
   AST_ENTRY_LENGTH: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      $rose(pad_float_o) |-> $past(entry_stb) == RST_MC - 1); // R3
   AST_FLOAT_CLOCKS_OFF: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      pad_float_o |-> !main_osc_en_o && !rc_osc_en_o && core_rst_o); // R4
   AST_RC_CLOCK_IN_RESET: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      clk_sel_rc_o |-> core_rst_o && rc_osc_en_o && osc_wd_en_i); // R7
   AST_RELEASE_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      $fell(core_rst_o) |-> !owd_flag_o && !clk_sel_rc_o); // R8
   AST_START_WITH_STRAP: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      wdt_start_o |-> !core_rst_o && wdt_auto_i); // R9
   AST_START_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!ext_rst_ni)
      wdt_start_o |=> !wdt_start_o); // R9
endmodule

bind pdw_ctrl pdw_ctrl_chk #(.RST_MC(RST_MC)) u_pdw_chk (
   .clk_i         (clk_i),
   .ext_rst_ni    (ext_rst_ni),
   .mc_stb_i      (mc_stb_i),
   .osc_wd_en_i   (osc_wd_en_i),
   .wdt_auto_i    (wdt_auto_i),
   .core_rst_o    (core_rst_o),
   .main_osc_en_o (main_osc_en_o),
   .rc_osc_en_o   (rc_osc_en_o),
   .pad_float_o   (pad_float_o),
   .clk_sel_rc_o  (clk_sel_rc_o),
   .owd_flag_o    (owd_flag_o),
   .wdt_start_o   (wdt_start_o),
   .state_q       (state_q)
);

// File: tb/pdw_ctrl_tb_top.sv
`timescale 1ns/1ps
module pdw_ctrl_tb_top;
   localparam int RST_MC = 5;

   logic clk = 1'b0;
   logic ext_rst_n = 1'b0, stb = 1'b0, pin_n = 1'b1;
   logic owe = 1'b1, auto = 1'b0, rdy = 1'b0;
   logic core_rst, main_en, rc_en, pfloat, sel_rc, oflag, wstart;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   pdw_ctrl #(.RST_MC(RST_MC), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .ext_rst_ni(ext_rst_n), .mc_stb_i(stb), .pd_pin_ni(pin_n),
      .osc_wd_en_i(owe), .wdt_auto_i(auto), .main_osc_rdy_i(rdy),
      .core_rst_o(core_rst), .main_osc_en_o(main_en), .rc_osc_en_o(rc_en),
      .pad_float_o(pfloat), .clk_sel_rc_o(sel_rc), .owd_flag_o(oflag),
      .wdt_start_o(wstart)
   );

   // phase: 0 run, 1 entry reset, 2 down, 3 pad restore, 4 osc wait,
   // 5 release, 6 run under external reset
   function automatic logic [6:0] ev(input int ph, input logic w, input logic a);
      case (ph)
         0: return {1'b0, 1'b1, w, 1'b0, 1'b0, 1'b0, a};
         1: return {1'b1, 1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0};
         2: return 7'b1_0_0_1_0_0_0;
         3: return 7'b1_0_0_0_0_0_0;
         4: return 7'b1_1_1_0_1_1_0;
         5: return 7'b1_1_1_0_0_0_0;
         default: return {1'b1, 1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0};
      endcase
   endfunction

   task automatic chk(input string req, input logic [6:0] exp);
      logic [6:0] act;
      act = {core_rst, main_en, rc_en, pfloat, sel_rc, oflag, wstart};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick();
      repeat (3) @(negedge clk);
      stb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      stb = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      ext_rst_n = 1'b0;
      pin_n = 1'b1; rdy = 1'b0;
      repeat (2) @(negedge clk);
      ext_rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      #1 chk("R1 in reset", ev(6, 1'b1, 1'b0));
      repeat (2) @(negedge clk);
      ext_rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", ev(0, 1'b1, 1'b0));

      // R2 short pulse that leaves the synchronizer before the strobe is ignored
      pin_n = 1'b0; @(negedge clk); pin_n = 1'b1;
      tick();
      chk("R2 short pulse ignored", ev(0, 1'b1, 1'b0));

      // full cycles over all strap combinations
      for (int sc = 0; sc < 4; sc++) begin
         logic w, a;
         w = sc[1]; a = sc[0];
         owe = w; auto = a;
         do_reset();
         chk("R9 rc enable follows strap", ev(0, w, 1'b0));
         pin_n = 1'b0;
         tick();
         chk("R2 entry at strobe", ev(1, w, 1'b0));
         for (int k = 1; k < RST_MC; k++) begin
            tick();
            chk("R3 entry reset held", ev(1, w, 1'b0));
         end
         tick();
         chk("R3 clocks off pads float", ev(2, w, 1'b0));
         for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 stays down", ev(2, w, 1'b0));
         end
         pin_n = 1'b1;
         tick();
         chk("R5 pads restored", ev(3, w, 1'b0));
         if (!w) begin
            rdy = 1'b1;
            for (int k = 0; k < 3; k++) begin
               tick();
               chk("R6 no strap stays off", ev(3, w, 1'b0));
            end
         end else begin
            tick();
            chk("R6 oscillators on rc clock", ev(4, w, 1'b0));
            for (int k = 0; k < 2; k++) begin
               tick();
               chk("R7 wait holds reset", ev(4, w, 1'b0));
            end
            rdy = 1'b1;
            tick();
            chk("R8 release flag clear", ev(5, w, 1'b0));
            tick();
            chk("R9 reset released start pulse", ev(0, w, a));
            @(negedge clk);
            chk("R9 start pulse one clock", ev(0, w, 1'b0));
         end
      end

      // R1 override from every state
      owe = 1'b1; auto = 1'b0;
      for (int s = 0; s < 6; s++) begin
         do_reset();
         if (s >= 1) begin pin_n = 1'b0; tick(); end
         if (s >= 2) repeat (RST_MC) tick();
         if (s >= 3) begin pin_n = 1'b1; tick(); end
         if (s >= 4) tick();
         if (s >= 5) begin rdy = 1'b1; tick(); end
         chk("R1 reached state", ev(s, 1'b1, 1'b0));
         pin_n = 1'b1; rdy = 1'b0;
         ext_rst_n = 1'b0;
         #1 chk("R1 override", ev(6, 1'b1, 1'b0));
         @(negedge clk);
         ext_rst_n = 1'b1;
         @(negedge clk);
         chk("R1 run after override", ev(0, 1'b1, 1'b0));
         tick();
         chk("R1 stays run", ev(0, 1'b1, 1'b0));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule